// File: doc/BRIEF.md
# UART with diagnostic channel modes

This block is a single-channel asynchronous serial transceiver. A two-bit channel-mode control reroutes its serial path for diagnostics. The transmitter takes one byte at a time through a valid strobe and a one-entry holding stage. The receiver oversamples the line sixteen times per bit and reports each byte with a one-clock valid pulse, together with parity, framing and break status. A single oversampling enable, `tick_i`, paces both directions. A bit therefore lasts sixteen ticks in each direction.

Besides normal operation there are three diagnostic modes:

- **Automatic echo** sends the incoming line straight back out. The receiver keeps working in this mode.
- **Local loopback** wires the transmitter into the receiver and holds the pin at idle.
- **Remote loopback** echoes the line but silences the receiver.

The echo path is a plain copy of the synchronized line. It performs no re-framing and no parity regeneration, so stop bits and breaks pass through exactly as they arrive. The requested mode is adopted only when both directions are quiet.

Top module: `sdiag_uart`

## Requirements
- R1: Mode codes are 00 normal, 01 automatic echo, 10 local loopback and 11 remote loopback. `mode_o` takes the value of `mode_req_i` only on a clock where the transmitter holds nothing and sends nothing, and the receiver is hunting for a start bit. A request made during a frame waits until that frame ends.
- R2: The transmitter is active only in normal or local loopback mode with `tx_en_i` high. In that case:
  - A `tx_valid_i` strobe while `tx_ready_o` is high loads the holding stage.
  - The frame on the line is a start bit of 0, then 8 data bits LSB first, then an optional parity bit (`par_en_i`), then a stop bit of 1.
  - The parity bit makes the count of ones even when `par_odd_i` is 0, and odd when `par_odd_i` is 1.
  - Every bit after the start bit lasts 16 ticks.
  - `tx_ready_o` is high while the holding stage is empty. `tx_empty_o` is high while the holding stage is empty and no frame is in progress.
- R3: The receiver accepts the same frame format. It confirms the start bit 8 ticks after first seeing the line low, then samples every 16 ticks.
  - Each frame with a high stop bit produces a one-clock `rx_valid_o` pulse with the byte on `rx_data_o`.
  - `par_err_o` shows whether that frame's parity was wrong. `frm_err_o` shows whether its stop bit was low.
  - Both flags hold until the next completed frame.
- R4: A frame whose data, parity and stop positions are all sampled low is a break. It raises `brk_o` and gives no `rx_valid_o` pulse. `brk_o` stays high until the next confirmed start bit after the line has returned high.
- R5: In echo and remote loopback modes, `ser_i` passes through two synchronizing flops. It is captured into an echo stage on every clock where `tick_i` is high, and appears on `ser_o` one clock later. Breaks and stop bits are copied unchanged.
- R6: In echo mode, the receiver still delivers bytes with parity and framing checked. `tx_ready_o` and `tx_empty_o` are low, and `tx_valid_i` has no effect on `ser_o`.
- R7: In local loopback mode:
  - `ser_o` stays 1.
  - `ser_i` is ignored.
  - The receiver decodes the transmitter's own output, whatever the level of `rx_en_i`.
- R8: In remote loopback mode:
  - `rx_valid_o`, `par_err_o`, `frm_err_o` and `brk_o` stay 0 whatever arrives.
  - `tx_ready_o` and `tx_empty_o` stay 0.
  - The line is echoed as in R5.
- R9: In normal mode, frames arriving while `rx_en_i` is low give no `rx_valid_o`. With `tx_en_i` low, `tx_ready_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| mode_req_i | input | 2 | Requested channel mode |
| tx_en_i | input | 1 | Transmitter enable |
| rx_en_i | input | 1 | Receiver enable |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Send strobe |
| tx_ready_o | output | 1 | Holding stage can take a byte |
| tx_empty_o | output | 1 | Transmitter fully idle |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-clock pulse per received byte |
| par_err_o | output | 1 | Last frame had bad parity |
| frm_err_o | output | 1 | Last frame had a low stop bit |
| brk_o | output | 1 | Break seen, not yet cleared |
| mode_o | output | 2 | Channel mode in force |
| ser_i | input | 1 | Serial line in |
| ser_o | output | 1 | Serial line out |

## Verification
The hardest situation to reach from the ports is a mode request that arrives in the middle of a transmitted frame. The bench starts a byte, issues the echo request well before the frame is over, confirms that the old mode is still in force, and then waits for the switch.

Echo and remote loopback are checked on every clock against a behavioural model of the line history. The model is fed with frames, bad parity and breaks, so a single misplaced bit of copy lag shows up at once.

Local loopback is exercised with `ser_i` pulled low for the whole transfer. If the pin were not really ignored, this would look like a break to the receiver.

// File: rtl/sdiag_pkg.sv
package sdiag_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_ECHO   = 2'b01,
        MODE_LOCAL  = 2'b10,
        MODE_REMOTE = 2'b11
    } chan_mode_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

endpackage

// File: rtl/sdiag_tx.sv
module sdiag_tx
    import sdiag_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          allow_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    output logic          ready_o,
    output logic          empty_o,
    output logic          idle_o,
    output logic          line_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DW - 1);

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic [DW-1:0] hold;
        logic          full;
        logic          par;
        logic          line;
    } tx_t;

    tx_t d, q;

    always_comb begin
        d = q;
        // Holding stage takes a new byte whenever it is empty.
        if (valid_i && allow_i && !q.full) begin
            d.hold = data_i;
            d.full = 1'b1;
        end
        if (q.st == TX_IDLE) begin
            d.line = 1'b1;
            if (q.full) begin
                d.st   = TX_START;
                d.sh   = q.hold;
                d.par  = (^q.hold) ^ par_odd_i;
                d.full = 1'b0;
                d.cnt  = '0;
                d.line = 1'b0;
            end
        end else if (tick_i) begin
            if (q.cnt == CNT_LAST) begin
                d.cnt = '0;
                case (q.st)
                    TX_START: begin
                        d.st   = TX_DATA;
                        d.idx  = '0;
                        d.line = q.sh[0];
                    end
                    TX_DATA: begin
                        d.sh = q.sh >> 1;
                        if (q.idx == IDX_LAST) begin
                            if (par_en_i) begin
                                d.st   = TX_PAR;
                                d.line = q.par;
                            end else begin
                                d.st   = TX_STOP;
                                d.line = 1'b1;
                            end
                        end else begin
                            d.idx  = q.idx + 1'b1;
                            d.line = q.sh[1];
                        end
                    end
                    TX_PAR: begin
                        d.st   = TX_STOP;
                        d.line = 1'b1;
                    end
                    default: begin
                        d.st   = TX_IDLE;
                        d.line = 1'b1;
                    end
                endcase
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready_o = allow_i && !q.full;
    assign empty_o = allow_i && !q.full && (q.st == TX_IDLE);
    assign idle_o  = !q.full && (q.st == TX_IDLE);
    assign line_o  = q.line;

    // R2: an accepted byte occupies the holding stage on the next clock
    a_r2_hold_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && ready_o) |=> !ready_o);

    // R2: the stop position always drives the marking level
    a_r2_stop_marking: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == TX_STOP) |-> line_o);

endmodule

// File: rtl/sdiag_rx.sv
module sdiag_rx
    import sdiag_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          line_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o,
    output logic          par_err_o,
    output logic          frm_err_o,
    output logic          brk_o,
    output logic          idle_o
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] CNT_LAST  = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(OSR / 2 - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DW - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pbit;
        logic [DW-1:0] data;
        logic          valid;
        logic          perr;
        logic          ferr;
        logic          brk;
    } rx_t;

    rx_t  d, q;
    logic par_bad;

    assign par_bad = par_en_i && (q.pbit != ((^q.sh) ^ par_odd_i));

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (!run_i) begin
            d.st  = RX_IDLE;
            d.cnt = '0;
        end else if (tick_i) begin
            case (q.st)
                RX_IDLE: begin
                    if (!line_i) begin
                        d.st  = RX_START;
                        d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (q.cnt == HALF_LAST) begin
                        d.cnt = '0;
                        if (!line_i) begin
                            d.st  = RX_DATA;
                            d.idx = '0;
                            d.brk = 1'b0;
                        end else begin
                            d.st = RX_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        d.sh  = {line_i, q.sh[DW-1:1]};
                        if (q.idx == IDX_LAST) begin
                            d.st = par_en_i ? RX_PAR : RX_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt  = '0;
                        d.pbit = line_i;
                        d.st   = RX_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        if (line_i) begin
                            d.valid = 1'b1;
                            d.data  = q.sh;
                            d.perr  = par_bad;
                            d.ferr  = 1'b0;
                            d.st    = RX_IDLE;
                        end else if ((q.sh == '0) && (!par_en_i || !q.pbit)) begin
                            d.brk = 1'b1;
                            d.st  = RX_WAITHI;
                        end else begin
                            d.valid = 1'b1;
                            d.data  = q.sh;
                            d.perr  = par_bad;
                            d.ferr  = 1'b1;
                            d.st    = RX_WAITHI;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (line_i) d.st = RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign data_o    = q.data;
    assign valid_o   = q.valid;
    assign par_err_o = q.perr;
    assign frm_err_o = q.ferr;
    assign brk_o     = q.brk;
    assign idle_o    = (q.st == RX_IDLE);

    // R3: each received byte is announced for exactly one clock
    a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R4: a break never presents a byte
    a_r4_break_no_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(brk_o) |-> !valid_o);

    // R8: a halted receiver returns to start-bit hunting
    a_r8_halt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> idle_o);

endmodule

// File: rtl/sdiag_uart.sv
module sdiag_uart
    import sdiag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [1:0]        mode_req_i,
    input  logic              tx_en_i,
    input  logic              rx_en_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              tx_empty_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic              brk_o,
    output logic [1:0]        mode_o,
    input  logic              ser_i,
    output logic              ser_o
);
    typedef struct packed {
        chan_mode_e mode;
        logic       s1;
        logic       s2;
        logic       echo;
        logic       ser;
    } top_t;

    top_t d, q;

    logic              tx_allow, tx_idle, tx_line;
    logic              rx_run, rx_idle, rx_line_src;
    logic [DATA_W-1:0] rx_data;
    logic              rx_valid, rx_perr, rx_ferr, rx_brk;
    logic              remote;

    assign remote      = (q.mode == MODE_REMOTE);
    assign tx_allow    = tx_en_i && ((q.mode == MODE_NORMAL) || (q.mode == MODE_LOCAL));
    assign rx_run      = (q.mode == MODE_LOCAL) || (rx_en_i && !remote);
    assign rx_line_src = (q.mode == MODE_LOCAL) ? tx_line : ser_i;

    sdiag_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .allow_i  (tx_allow),
        .par_en_i (par_en_i),
        .par_odd_i(par_odd_i),
        .data_i   (tx_data_i),
        .valid_i  (tx_valid_i),
        .ready_o  (tx_ready_o),
        .empty_o  (tx_empty_o),
        .idle_o   (tx_idle),
        .line_o   (tx_line)
    );

    sdiag_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .run_i    (rx_run),
        .line_i   (q.s2),
        .par_en_i (par_en_i),
        .par_odd_i(par_odd_i),
        .data_o   (rx_data),
        .valid_o  (rx_valid),
        .par_err_o(rx_perr),
        .frm_err_o(rx_ferr),
        .brk_o    (rx_brk),
        .idle_o   (rx_idle)
    );

    always_comb begin
        d    = q;
        d.s1 = rx_line_src;
        d.s2 = q.s1;
        if (tick_i) d.echo = q.s2;
        if (tx_idle && rx_idle) d.mode = chan_mode_e'(mode_req_i);
        case (q.mode)
            MODE_NORMAL: d.ser = tx_line;
            MODE_LOCAL:  d.ser = 1'b1;
            default:     d.ser = q.echo;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{mode: MODE_NORMAL, s1: 1'b1, s2: 1'b1, echo: 1'b1, ser: 1'b1};
        else         q <= d;
    end

    assign ser_o      = q.ser;
    assign mode_o     = q.mode;
    assign rx_data_o  = rx_data;
    assign rx_valid_o = rx_valid && !remote;
    assign par_err_o  = rx_perr && !remote;
    assign frm_err_o  = rx_ferr && !remote;
    assign brk_o      = rx_brk && !remote;

    // R1: the channel mode moves only while both directions are quiet
    a_r1_mode_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.mode != $past(q.mode)) |-> $past(tx_idle && rx_idle));

    // R5: the echo stage changes only on an oversampling tick
    a_r5_echo_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.echo != $past(q.echo)) |-> $past(tick_i));

    // R7: one clock spent in local loopback leaves the pin marking
    a_r7_local_marking: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(q.mode) == MODE_LOCAL) |-> ser_o);

    // R8: the transmitter never offers itself in remote loopback
    a_r8_remote_no_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        remote |-> (!tx_ready_o && !tx_empty_o));

endmodule

// File: tb/sim_sdiag_uart.sv
module sim_sdiag_uart;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int TDIV       = 2;
    localparam int BIT_CLKS   = OSR * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] mode_req = 2'b00;
    logic       tx_en = 1'b0, rx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, tx_empty, rx_valid, par_err, frm_err, brk;
    logic [7:0] rx_data;
    logic [1:0] mode_o;
    logic       ser_i = 1'b1;
    logic       ser_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int tdc    = 0;
    int got_d[$], got_pe[$], got_fe[$];

    // per-clock line model
    int h1 = 1, h2 = 1, echo_m = 1, exp_ser = -1, exp_mode = 0;

    sdiag_uart u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_req_i(mode_req),
        .tx_en_i(tx_en), .rx_en_i(rx_en), .par_en_i(par_en), .par_odd_i(par_odd),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .tx_empty_o(tx_empty), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .par_err_o(par_err), .frm_err_o(frm_err), .brk_o(brk), .mode_o(mode_o),
        .ser_i(ser_i), .ser_o(ser_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            tdc  = 0;
            tick = 1'b0;
        end else begin
            tick = (tdc == 0);
            tdc  = (tdc == TDIV - 1) ? 0 : tdc + 1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
            summary();
        end
        if (!rst_n) begin
            h1 = 1; h2 = 1; echo_m = 1; exp_ser = -1;
        end else begin
            exp_mode = int'(mode_o);
            if (mode_o == 2'b10)                          exp_ser = 1;
            else if (mode_o == 2'b01 || mode_o == 2'b11)  exp_ser = echo_m;
            else                                          exp_ser = -1;
            if (tick) echo_m = h2;
            h2 = h1;
            h1 = int'(ser_i);
        end
    end

    always @(negedge clk) begin
        if (rst_n && exp_ser >= 0) begin
            if (exp_mode == 2)      chk(ser_o == exp_ser[0], "R7", "pin marking", int'(ser_o), exp_ser);
            else if (exp_mode == 1) chk(ser_o == exp_ser[0], "R5", "echo copy", int'(ser_o), exp_ser);
            else                    chk(ser_o == exp_ser[0], "R8", "remote copy", int'(ser_o), exp_ser);
        end
        if (rst_n && rx_valid) begin
            got_d.push_back(int'(rx_data));
            got_pe.push_back(int'(par_err));
            got_fe.push_back(int'(frm_err));
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop);
        ser_i = 1'b0;
        wait_clk(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            ser_i = d[i];
            wait_clk(BIT_CLKS);
        end
        if (par_en) begin
            ser_i = (^d) ^ par_odd ^ bad_par;
            wait_clk(BIT_CLKS);
        end
        ser_i = stop;
        wait_clk(BIT_CLKS);
        ser_i = 1'b1;
        wait_clk(BIT_CLKS);
    endtask

    task automatic send_break();
        ser_i = 1'b0;
        wait_clk(BIT_CLKS * 12);
        ser_i = 1'b1;
        wait_clk(BIT_CLKS * 2);
    endtask

    task automatic expect_rx(input int d, input int pe, input int fe, input string req);
        chk(got_d.size() == 1, req, "byte count", got_d.size(), 1);
        if (got_d.size() > 0) begin
            int gd, gp, gf;
            gd = got_d.pop_front();
            gp = got_pe.pop_front();
            gf = got_fe.pop_front();
            chk(gd == d, req, "rx byte", gd, d);
            chk(gp == pe, req, "parity flag", gp, pe);
            chk(gf == fe, req, "framing flag", gf, fe);
        end
        got_d.delete(); got_pe.delete(); got_fe.delete();
    endtask

    task automatic expect_none(input string req);
        chk(got_d.size() == 0, req, "unexpected byte count", got_d.size(), 0);
        got_d.delete(); got_pe.delete(); got_fe.delete();
    endtask

    task automatic tx_send(input logic [7:0] d);
        for (int i = 0; i < 2000 && !tx_ready; i++) @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        wait_clk(1);
        tx_valid = 1'b0;
    endtask

    task automatic tx_check_line(input logic [7:0] d, input string req);
        for (int i = 0; i < 400 && ser_o !== 1'b0; i++) @(negedge clk);
        wait_clk(BIT_CLKS / 2);
        chk(ser_o == 1'b0, req, "start bit", int'(ser_o), 0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BIT_CLKS);
            chk(ser_o == d[i], req, "data bit", int'(ser_o), int'(d[i]));
        end
        if (par_en) begin
            wait_clk(BIT_CLKS);
            chk(ser_o == ((^d) ^ par_odd), req, "parity bit", int'(ser_o), int'((^d) ^ par_odd));
        end
        wait_clk(BIT_CLKS);
        chk(ser_o == 1'b1, req, "stop bit", int'(ser_o), 1);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_req = m;
        for (int i = 0; i < 2000 && mode_o != m; i++) @(negedge clk);
        chk(mode_o == m, "R1", "mode adopted", int'(mode_o), int'(m));
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // reset state
        chk(ser_o == 1'b1, "R2", "reset line idle", int'(ser_o), 1);
        chk(mode_o == 2'b00, "R1", "reset mode", int'(mode_o), 0);
        chk(brk == 1'b0, "R4", "reset break flag", int'(brk), 0);
        chk(tx_ready == 1'b0, "R9", "ready with tx disabled", int'(tx_ready), 0);

        tx_en = 1'b1; rx_en = 1'b1;
        wait_clk(2);
        chk(tx_ready && tx_empty, "R2", "ready and empty when enabled", int'({tx_ready, tx_empty}), 3);

        // normal reception
        send_frame(8'hA5, 1'b0, 1'b1);
        expect_rx(8'hA5, 0, 0, "R3");
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h3C, 1'b0, 1'b1);
        expect_rx(8'h3C, 0, 0, "R3");
        send_frame(8'h3C, 1'b1, 1'b1);
        expect_rx(8'h3C, 1, 0, "R3");
        par_odd = 1'b1;
        send_frame(8'h81, 1'b0, 1'b1);
        expect_rx(8'h81, 0, 0, "R3");
        par_en = 1'b0;
        send_frame(8'h55, 1'b0, 1'b0);
        expect_rx(8'h55, 0, 1, "R3");

        // break and its clearing
        send_break();
        chk(brk == 1'b1, "R4", "break flagged", int'(brk), 1);
        expect_none("R4");
        wait_clk(BIT_CLKS * 2);
        chk(brk == 1'b1, "R4", "break held while idle", int'(brk), 1);
        send_frame(8'h0F, 1'b0, 1'b1);
        chk(brk == 1'b0, "R4", "break cleared by start", int'(brk), 0);
        expect_rx(8'h0F, 0, 0, "R4");

        // receiver disabled
        rx_en = 1'b0;
        send_frame(8'h77, 1'b0, 1'b1);
        expect_none("R9");
        rx_en = 1'b1;

        // normal transmission
        tx_send(8'h96);
        wait_clk(1);
        chk(tx_empty == 1'b0, "R2", "empty low while sending", int'(tx_empty), 0);
        tx_check_line(8'h96, "R2");
        par_en = 1'b1; par_odd = 1'b1;
        tx_send(8'h07);
        tx_check_line(8'h07, "R2");
        wait_clk(BIT_CLKS);
        chk(tx_empty == 1'b1, "R2", "empty after frame", int'(tx_empty), 1);
        par_en = 1'b0;

        // mode request during a frame is deferred
        tx_send(8'hF0);
        wait_clk(40);
        mode_req = 2'b01;
        wait_clk(60);
        chk(mode_o == 2'b00, "R1", "mode held mid-frame", int'(mode_o), 0);
        set_mode(2'b01);

        // echo mode
        wait_clk(4);
        chk(!tx_ready && !tx_empty, "R6", "tx flags in echo", int'({tx_ready, tx_empty}), 0);
        tx_data = 8'h00; tx_valid = 1'b1;
        wait_clk(1);
        tx_valid = 1'b0;
        par_en = 1'b1; par_odd = 1'b0;
        send_frame(8'h5A, 1'b1, 1'b1);
        expect_rx(8'h5A, 1, 0, "R6");
        send_break();
        chk(brk == 1'b1, "R6", "break seen in echo", int'(brk), 1);
        send_frame(8'h33, 1'b0, 1'b1);
        expect_rx(8'h33, 0, 0, "R6");

        // local loopback, pin driven low to prove it is ignored
        set_mode(2'b10);
        rx_en = 1'b0; par_odd = 1'b1;
        ser_i = 1'b0;
        tx_send(8'hC3);
        wait_clk(4);
        for (int i = 0; i < 1000 && !tx_empty; i++) @(negedge clk);
        wait_clk(4);
        expect_rx(8'hC3, 0, 0, "R7");
        ser_i = 1'b1;
        wait_clk(10);

        // remote loopback
        rx_en = 1'b1; par_odd = 1'b0;
        set_mode(2'b11);
        wait_clk(2);
        chk(!tx_ready && !tx_empty, "R8", "tx flags in remote", int'({tx_ready, tx_empty}), 0);
        send_frame(8'h5A, 1'b1, 1'b1);
        expect_none("R8");
        chk(par_err == 1'b0, "R8", "parity flag quiet", int'(par_err), 0);
        send_frame(8'h12, 1'b0, 1'b0);
        chk(frm_err == 1'b0, "R8", "framing flag quiet", int'(frm_err), 0);
        send_break();
        chk(brk == 1'b0, "R8", "break flag quiet", int'(brk), 0);
        expect_none("R8");

        set_mode(2'b00);
        wait_clk(10);
        summary();
    end
endmodule